// File: doc/BRIEF.md
# Hot-Way Write Restriction Selector

This block spreads write wear across the ways of a set-associative cache built from memory cells with limited write endurance. It keeps one saturating write counter per way and a free-running interval timer. At the end of every interval it finds the ways that took the most writes and marks them write-restricted for the whole of the next interval. The cache controller reads the restriction mask and sends writes that hit a restricted way to some other way.

The controller reports every write that is served through a single-cycle strobe. The strobe carries the index of the way that actually received the data, which for a redirected write is the destination way. At an interval boundary the block runs one max-search per clock cycle. Each search picks the highest counter among the ways not yet chosen and clears that counter. After the requested number of searches, the new mask replaces the old one in a single step. The first interval after reset is a warm-up interval in which no way is restricted.

Top module: `hot_way_restrict_sel`

## Requirements
- R1: From reset until the first selection completes, `restrict_mask` is all zeros.
- R2: `interval_pulse` is high for one cycle every `cfg_interval` cycles. The first pulse appears in cycle `cfg_interval`-1, counting the first cycle after reset release as cycle 0.
- R3: Each cycle with `wr_valid` high adds one to the counter of way `wr_way`.
- R4: Selection makes n passes. Each pass takes the way with the largest counter among the ways not yet taken, and a tie goes to the lowest way index. Bit k of `restrict_mask` stands for way k.
- R5: Selection clears only the counters of the chosen ways. All other counters carry their values into the next interval.
- R6: `select_busy` is high for exactly n cycles, starting the cycle after the pulse. `restrict_mask` changes only at the edge that ends the last pass, and it is held constant until the next selection completes.
- R7: n is `cfg_num_restrict` limited to the number of ways, and it is sampled at the pulse. After each selection exactly n mask bits are set. With n = 0 the mask becomes zero in the cycle after the pulse.
- R8: A counter saturates at 2^CNT_W-1 and does not wrap. With CNT_W = 8 this is 255.
- R9: A write that arrives while selection runs still counts. If it lands in the same cycle as a clear of its way, the counter becomes 1.
- R10: Synchronous active-low reset clears all counters, the timer, the mask and the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_interval | input | IVL_W | Interval length in cycles (0 behaves as 1) |
| cfg_num_restrict | input | SEL_W | Number of ways to restrict per interval |
| wr_valid | input | 1 | A write was served this cycle |
| wr_way | input | WAY_W | Way that received the write |
| restrict_mask | output | NUM_WAYS | Write-restricted ways, bit k is way k |
| interval_pulse | output | 1 | One-cycle strobe on the last cycle of each interval |
| select_busy | output | 1 | Selection passes in progress |

## Verification
A wrong counter value does not appear at the ports right away. It shows up at the next interval boundary as a wrong bit in the new mask, and a cleared counter that retained its value shows up one interval later still. For this reason the bench runs several intervals in sequence and compares every mask against a running model of the counter values. A timer fault shifts `interval_pulse` by at least one cycle, and a fault in the pass control changes the length of `select_busy` or the number of set mask bits within n+1 cycles of the pulse.

// File: rtl/hwr_pkg.sv
`timescale 1ns/1ps
// Shared types for the hot-way write restriction selector.
package hwr_pkg;
    // Selection controller phase.
    typedef enum logic {
        SEL_IDLE = 1'b0,
        SEL_RUN  = 1'b1
    } sel_state_e;
endpackage

// File: rtl/hwr_interval_timer.sv
`timescale 1ns/1ps
// Interval timer: counts cycles and raises a one-cycle strobe on the last
// cycle of every interval. Assumes cfg_interval is held steady by software;
// a value of 0 behaves as 1.
module hwr_interval_timer #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] cfg_interval,
    output logic             interval_pulse
);
    logic [IVL_W-1:0] tick_q;
    logic [IVL_W:0]   tick_nxt;

    // Next count and end-of-interval detection.
    always_comb begin
        tick_nxt       = {1'b0, tick_q} + (IVL_W+1)'(1);
        interval_pulse = (tick_nxt >= {1'b0, cfg_interval});
    end

    // Cycle counter, wraps to zero on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              tick_q <= '0;
        else if (interval_pulse) tick_q <= '0;
        else                     tick_q <= tick_nxt[IVL_W-1:0];
    end

    // R2: the strobe lasts a single cycle when the interval is longer than one.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_pulse && cfg_interval > 1) |=> (!interval_pulse || cfg_interval <= 1));
endmodule

// File: rtl/hwr_way_counters.sv
`timescale 1ns/1ps
// Per-way saturating write counters. Assumes at most one write per cycle.
// A clear and a write to the same way in one cycle leave the counter at 1.
module hwr_way_counters #(
    parameter int NUM_WAYS = 16,
    parameter int CNT_W    = 8,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_valid,
    input  logic [WAY_W-1:0]                   wr_way,
    input  logic [NUM_WAYS-1:0]                clr_vec,
    output logic [NUM_WAYS-1:0][CNT_W-1:0]     cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar j = 0; j < NUM_WAYS; j++) begin : g_way
        logic inc;
        logic [CNT_W-1:0] cnt_q;

        // Decode whether this way is written this cycle.
        always_comb inc = wr_valid && (wr_way == WAY_W'(j));

        // Counter update: clear has priority, increment saturates.
        always_ff @(posedge clk) begin
            if (!rst_n)                          cnt_q <= '0;
            else if (clr_vec[j])                 cnt_q <= {{(CNT_W-1){1'b0}}, inc};
            else if (inc && cnt_q != CNT_MAX)    cnt_q <= cnt_q + CNT_W'(1);
        end

        assign cnt[j] = cnt_q;

        // R8: a full counter stays full under further writes.
        a_r8_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == CNT_MAX && inc && !clr_vec[j]) |=> (cnt_q == CNT_MAX));
    end
endmodule

// File: rtl/hwr_max_finder.sv
`timescale 1ns/1ps
// Combinational arg-max over all way counters, skipping excluded ways.
// Ties resolve to the lowest index. Assumes at least one way is not excluded
// whenever the result is used.
module hwr_max_finder #(
    parameter int NUM_WAYS = 16,
    parameter int CNT_W    = 8,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][CNT_W-1:0] cnt,
    input  logic [NUM_WAYS-1:0]            excl,
    output logic [WAY_W-1:0]               best_idx
);
    logic [CNT_W-1:0] best_val;
    logic             found;

    // Linear scan; strict greater-than keeps the lower index on ties.
    always_comb begin
        best_idx = '0;
        best_val = '0;
        found    = 1'b0;
        for (int j = 0; j < NUM_WAYS; j++) begin
            if (!excl[j] && (!found || cnt[j] > best_val)) begin
                best_idx = WAY_W'(j);
                best_val = cnt[j];
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hwr_select_ctrl.sv
`timescale 1ns/1ps
// Selection sequencer: on an interval strobe it runs n passes, one per cycle,
// taking the finder's result each pass, clearing that way's counter and
// finally publishing the new mask in one step. A strobe while busy is ignored.
module hwr_select_ctrl
    import hwr_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    parameter int WAY_W    = $clog2(NUM_WAYS),
    parameter int SEL_W    = $clog2(NUM_WAYS+1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SEL_W-1:0]    cfg_num,
    input  logic [WAY_W-1:0]    best_idx,
    output logic [NUM_WAYS-1:0] picked,
    output logic [NUM_WAYS-1:0] clr_vec,
    output logic [NUM_WAYS-1:0] mask,
    output logic                busy
);
    localparam logic [SEL_W-1:0] N_MAX = SEL_W'(NUM_WAYS);

    sel_state_e          state_q;
    logic [SEL_W-1:0]    pass_q;
    logic [SEL_W-1:0]    target_q;
    logic [SEL_W-1:0]    n_eff;
    logic [NUM_WAYS-1:0] pick_oh;
    logic                last_pass;

    // Clamp request, decode current pick, detect final pass.
    always_comb begin
        n_eff     = (cfg_num > N_MAX) ? N_MAX : cfg_num;
        pick_oh   = NUM_WAYS'(1) << best_idx;
        busy      = (state_q == SEL_RUN);
        clr_vec   = busy ? pick_oh : '0;
        last_pass = (pass_q + SEL_W'(1) == target_q);
    end

    // Pass sequencing and mask publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEL_IDLE;
            pass_q   <= '0;
            target_q <= '0;
            picked   <= '0;
            mask     <= '0;
        end else if (state_q == SEL_IDLE) begin
            if (start) begin
                pass_q   <= '0;
                picked   <= '0;
                target_q <= n_eff;
                if (n_eff == '0) mask    <= '0;
                else             state_q <= SEL_RUN;
            end
        end else begin
            picked <= picked | pick_oh;
            pass_q <= pass_q + SEL_W'(1);
            if (last_pass) begin
                mask    <= picked | pick_oh;
                state_q <= SEL_IDLE;
            end
        end
    end

    // R4: a pass never takes a way already taken in this selection.
    a_r4_fresh_pick: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !picked[best_idx]);

    // R7: the published mask holds exactly the requested number of ways.
    a_r7_mask_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($countones(mask) == int'(target_q)));
endmodule

// File: rtl/hot_way_restrict_sel.sv
`timescale 1ns/1ps
// Hot-way write restriction selector. Counts served writes per way and, at
// every interval end, restricts the most-written ways for the next interval.
// Assumes wr_way names the way that actually received the data.
module hot_way_restrict_sel #(
    parameter int NUM_WAYS = 16,
    parameter int CNT_W    = 8,
    parameter int IVL_W    = 16,
    parameter int WAY_W    = $clog2(NUM_WAYS),
    parameter int SEL_W    = $clog2(NUM_WAYS+1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IVL_W-1:0]    cfg_interval,
    input  logic [SEL_W-1:0]    cfg_num_restrict,
    input  logic                wr_valid,
    input  logic [WAY_W-1:0]    wr_way,
    output logic [NUM_WAYS-1:0] restrict_mask,
    output logic                interval_pulse,
    output logic                select_busy
);
    logic [NUM_WAYS-1:0][CNT_W-1:0] way_cnt;
    logic [NUM_WAYS-1:0]            clr_vec;
    logic [NUM_WAYS-1:0]            picked;
    logic [WAY_W-1:0]               best_idx;

    hwr_interval_timer #(.IVL_W(IVL_W)) i_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_interval   (cfg_interval),
        .interval_pulse (interval_pulse)
    );

    hwr_way_counters #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)) i_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_way   (wr_way),
        .clr_vec  (clr_vec),
        .cnt      (way_cnt)
    );

    hwr_max_finder #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)) i_finder (
        .cnt      (way_cnt),
        .excl     (picked),
        .best_idx (best_idx)
    );

    hwr_select_ctrl #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .SEL_W(SEL_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (interval_pulse),
        .cfg_num  (cfg_num_restrict),
        .best_idx (best_idx),
        .picked   (picked),
        .clr_vec  (clr_vec),
        .mask     (restrict_mask),
        .busy     (select_busy)
    );

    // R6: outside a selection and its trigger cycle the mask does not move.
    a_r6_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(select_busy) && !$past(interval_pulse)) |-> $stable(restrict_mask));
endmodule

// File: tb/test_hot_way_restrict_sel.sv
`timescale 1ns/1ps
module test_hot_way_restrict_sel;
    localparam int NW = 16, CW = 8, IW = 16, SW = 5, CMAX = 255;

    logic clk = 1'b0;
    logic rst_n;
    logic [IW-1:0] cfg_interval;
    logic [SW-1:0] cfg_n;
    logic wr_valid;
    logic [3:0] wr_way;
    logic [NW-1:0] mask;
    logic pulse, busy;

    hot_way_restrict_sel #(.NUM_WAYS(NW), .CNT_W(CW), .IVL_W(IW)) i_hot_way_restrict_sel (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_num_restrict(cfg_n),
        .wr_valid(wr_valid), .wr_way(wr_way), .restrict_mask(mask),
        .interval_pulse(pulse), .select_busy(busy)
    );

    always #2.5 clk = ~clk;

    // Per interval: four bursts of {way, write count}.
    localparam int VEC [6][8] = '{
        '{3, 10, 7, 8, 12, 6, 1, 6},
        '{0, 5, 9, 5, 14, 5, 2, 9},
        '{5, 12, 6, 12, 8, 1, 15, 14},
        '{11, 3, 13, 3, 10, 3, 4, 3},
        '{2, 20, 2, 10, 9, 4, 1, 2},
        '{15, 9, 0, 9, 7, 9, 12, 9}
    };

    int checks = 0, fails = 0;
    int mdl [NW];
    logic [NW-1:0] exp_mask;
    int since_pulse;
    bit first_ivl, pulse_seen, done = 0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge, checking mask hold and pulse spacing.
    task automatic step();
        @(negedge clk);
        since_pulse++;
        if (!busy) chk(mask === exp_mask, first_ivl ? "R1" : "R6", mask, exp_mask);
        if (pulse === 1'b1) begin
            chk(since_pulse == (first_ivl ? int'(cfg_interval) - 1 : int'(cfg_interval)),
                "R2", since_pulse, first_ivl ? int'(cfg_interval) - 1 : int'(cfg_interval));
            since_pulse = 0;
            first_ivl   = 0;
            pulse_seen  = 1;
        end
    endtask

    function automatic logic [NW-1:0] model_select(int n);
        logic [NW-1:0] m = '0;
        int ne = (n > NW) ? NW : n;
        for (int p = 0; p < ne; p++) begin
            int best = -1;
            for (int j = 0; j < NW; j++)
                if (!m[j] && (best < 0 || mdl[j] > mdl[best])) best = j;
            m[best] = 1'b1;
            mdl[best] = 0;
        end
        return m;
    endfunction

    task automatic burst(int w, int c);
        for (int i = 0; i < c; i++) begin
            wr_valid = 1'b1;
            wr_way   = 4'(w);
            step();
            if (mdl[w] < CMAX) mdl[w]++;
        end
        wr_valid = 1'b0;
    endtask

    // Wait for a boundary, then check busy length, new mask and its size.
    task automatic wait_pulse(int n, int late_way, string req);
        logic [NW-1:0] nm;
        int ne = (n > NW) ? NW : n;
        pulse_seen = 0;
        while (!pulse_seen) step();
        nm = model_select(n);
        for (int i = 0; i < ne; i++) begin
            step();
            chk(busy === 1'b1, "R6", busy, 1);
            if (i == ne - 1 && late_way >= 0) begin
                wr_valid = 1'b1;
                wr_way   = 4'(late_way);
            end
        end
        exp_mask = nm;
        step();
        wr_valid = 1'b0;
        if (late_way >= 0 && mdl[late_way] < CMAX) mdl[late_way]++;
        chk(busy === 1'b0, "R6", busy, 0);
        chk(mask === nm, req, mask, nm);
        chk($countones(mask) == ne, "R7", $countones(mask), ne);
    endtask

    initial begin
        rst_n = 1'b0; cfg_interval = 16'd64; cfg_n = 5'd4; wr_valid = 1'b0; wr_way = '0;
        repeat (3) @(negedge clk);
        chk(mask === '0, "R10", mask, 0);
        chk(busy === 1'b0, "R10", busy, 0);
        chk(pulse === 1'b0, "R10", pulse, 0);
        rst_n = 1'b1;
        since_pulse = 0; first_ivl = 1; exp_mask = '0;
        for (int j = 0; j < NW; j++) mdl[j] = 0;

        // Table walk: R3 R4 R5 over six consecutive intervals.
        for (int v = 0; v < 6; v++) begin
            for (int b = 0; b < 4; b++) burst(VEC[v][2*b], VEC[v][2*b+1]);
            wait_pulse(4, -1, "R3 R4 R5");
        end

        // R7: request above the way count is clamped; all counters cleared.
        cfg_n = 5'd20;
        wait_pulse(20, -1, "R7");
        burst(3, 2);
        burst(5, 2);
        cfg_n = 5'd1;
        // Tie between ways 3 and 5 goes to way 3; write to way 5 in last pass.
        wait_pulse(1, 5, "R4");
        burst(4, 2);
        // R9: the write during selection makes way 5 beat way 4.
        wait_pulse(1, -1, "R9");
        cfg_n = 5'd0;
        wait_pulse(0, -1, "R7");
        cfg_n = 5'd4;
        burst(6, 3);
        wait_pulse(4, -1, "R5");

        // R10: reset mid-run clears the mask.
        rst_n = 1'b0;
        exp_mask = '0;
        step();
        chk(mask === '0, "R10", mask, 0);
        chk(busy === 1'b0, "R10", busy, 0);
        cfg_interval = 16'd700;
        cfg_n = 5'd1;
        step();
        rst_n = 1'b1;
        since_pulse = 0; first_ivl = 1;
        for (int j = 0; j < NW; j++) mdl[j] = 0;

        // R8: 300 writes saturate way 9 at 255, tying way 3; way 3 wins.
        burst(9, 300);
        burst(3, 260);
        wait_pulse(1, -1, "R8");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule